// File: doc/BRIEF.md
# Single-Wire Peripheral Power-State Controller

This block decides when a device attached to a single-wire line is asleep and when it is awake. While the device sleeps, any change of level on the line wakes it. An ordinary data bit counts, so a wake pulse is not needed. After a wake, the controller holds the bit receiver disabled for a fixed settling delay. Line edges that arrive during that delay are dropped and do not lengthen it.

Once active, the receiver is enabled. An idle timer puts the device back to sleep when the line shows no edges for the configured number of cycles. The idle timer is held while the command-busy input is high. Every line edge restarts it.

A fail-safe watchdog starts counting at each wake and cannot be cleared by line activity or by the busy input. When it runs out, the controller passes through a one-cycle forced-sleep state and then returns to sleep, even mid-command or mid-transfer. Only a new sleep-then-wake cycle restarts the watchdog. The line input is sampled through a two-stage synchronizer, so a line change reaches the state register on the third rising clock edge after it occurs. All delays are parameters in clock cycles, and the watchdog interval must exceed both of the other two.

Top module: `line_power_ctrl`

## Requirements
- R1: After reset, `asleep_o`=1, `awake_o`=0 and `rx_en_o`=0.
- R2: While asleep, a line change in either direction (falling or rising) makes `asleep_o` fall and `awake_o` rise on the third rising clock edge after the change.
- R3: After a wake, `rx_en_o` stays 0 for exactly `WAKE_DLY` cycles of `awake_o`=1 and then rises.
- R4: Line edges during the wake-up delay are ignored: the delay is not lengthened and the device does not go back to sleep.
- R5: In the active state, with `busy_i` low and no line edges, the device returns to sleep (`asleep_o`=1, `awake_o`=0, `rx_en_o`=0) `IDLE_TMO` cycles after becoming active.
- R6: Each line edge seen while active restarts the idle timer from zero.
- R7: While `busy_i` is high, the idle timer holds its count. Counting resumes when `busy_i` falls.
- R8: Exactly `WDOG_CYC` cycles after the wake (counted from the first cycle with `awake_o`=1), the controller spends one cycle with `asleep_o`, `awake_o` and `rx_en_o` all 0, and then sleeps. This happens whatever `busy_i` and line activity are doing.
- R9: Neither line edges nor `busy_i` restart the watchdog. A sleep followed by a new wake gives a full new `WDOG_CYC` interval.
- R10: Output encoding: `asleep_o`=1 only in sleep. `awake_o`=1 during the wake-up delay and in the active state. `rx_en_o`=1 only in the active state. `asleep_o` and `awake_o` are never both 1, and both are 0 only in the forced-sleep cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Sensed level of the single-wire line (asynchronous) |
| busy_i | input | 1 | High while a command is executing; holds the idle timer |
| asleep_o | output | 1 | Device is in sleep |
| awake_o | output | 1 | Device is powered (wake-up delay or active) |
| rx_en_o | output | 1 | Enables the bit receiver |

## Verification
The assertions assume the following about the inputs:
- `busy_i` is synchronous to `clk`.
- The line idles at the reset level (high) while reset is applied, so that no edge appears when reset is released.
- The parameters satisfy `WDOG_CYC` > `WAKE_DLY` and `WDOG_CYC` > `IDLE_TMO`.

The stimulus drives both inputs only on falling clock edges. It holds the line high through reset. It stops toggling the line several cycles before each expected sleep, so that a stale edge still in the synchronizer cannot cause a fresh wake that would mask the event under test.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  typedef enum logic [1:0] {
    ST_SLEEP  = 2'd0,
    ST_WAKING = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_FORCE  = 2'd3
  } lpc_state_e;
endpackage

// File: rtl/lpc_line_edge.sv
module lpc_line_edge #(
  parameter int   STAGES     = 2,
  parameter logic IDLE_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic edge_o
);
  // pipe[STAGES-1] is the synchronized level; pipe[STAGES] holds its previous value
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {(STAGES+1){IDLE_LEVEL}};
    else        pipe <= {pipe[STAGES-1:0], line_i};
  end

  assign edge_o = pipe[STAGES] ^ pipe[STAGES-1];
endmodule

// File: rtl/lpc_cycle_timer.sv
module lpc_cycle_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr_i)             cnt <= '0;
    else if (en_i && !done_o)   cnt <= cnt + 1'b1;
  end

  assign done_o = (cnt == LAST);
endmodule

// File: rtl/lpc_state_fsm.sv
module lpc_state_fsm
  import lpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       edge_i,
  input  logic       busy_i,
  input  logic       wake_done_i,
  input  logic       idle_done_i,
  input  logic       wd_done_i,
  output lpc_state_e state_o
);
  lpc_state_e nxt;

  always_comb begin
    nxt = state_o;
    unique case (state_o)
      ST_SLEEP:  if (edge_i) nxt = ST_WAKING;
      ST_WAKING: begin
        if (wd_done_i)        nxt = ST_FORCE;
        else if (wake_done_i) nxt = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (wd_done_i)                             nxt = ST_FORCE;
        else if (idle_done_i && !busy_i && !edge_i) nxt = ST_SLEEP;
      end
      ST_FORCE:  nxt = ST_SLEEP;
      default:   nxt = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_o <= ST_SLEEP;
    else        state_o <= nxt;
  end
endmodule

// File: rtl/line_power_ctrl.sv
module line_power_ctrl
  import lpc_pkg::*;
#(
  parameter int WAKE_DLY = 16,
  parameter int IDLE_TMO = 64,
  parameter int WDOG_CYC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic busy_i,
  output logic asleep_o,
  output logic awake_o,
  output logic rx_en_o
);
  lpc_state_e state;
  logic       line_edge;
  logic       wake_done, idle_done, wd_done;
  logic       in_sleep, in_waking, in_active;

  assign in_sleep  = (state == ST_SLEEP);
  assign in_waking = (state == ST_WAKING);
  assign in_active = (state == ST_ACTIVE);

  lpc_line_edge #(.STAGES(2), .IDLE_LEVEL(1'b1)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (line_i),
    .edge_o (line_edge)
  );

  lpc_cycle_timer #(.LIMIT(WAKE_DLY)) u_wake_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (!in_waking),
    .en_i   (1'b1),
    .done_o (wake_done)
  );

  lpc_cycle_timer #(.LIMIT(IDLE_TMO)) u_idle_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (!in_active || line_edge),
    .en_i   (!busy_i),
    .done_o (idle_done)
  );

  // only leaving the awake states clears the watchdog
  lpc_cycle_timer #(.LIMIT(WDOG_CYC)) u_wd_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (!(in_waking || in_active)),
    .en_i   (1'b1),
    .done_o (wd_done)
  );

  lpc_state_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .edge_i      (line_edge),
    .busy_i      (busy_i),
    .wake_done_i (wake_done),
    .idle_done_i (idle_done),
    .wd_done_i   (wd_done),
    .state_o     (state)
  );

  assign asleep_o = in_sleep;
  assign awake_o  = in_waking || in_active;
  assign rx_en_o  = in_active;
endmodule

// File: rtl/lpc_checker.sv
module lpc_checker #(
  parameter int WAKE_DLY = 16,
  parameter int WDOG_CYC = 1024
) (
  input logic clk,
  input logic rst_n,
  input logic asleep_o,
  input logic awake_o,
  input logic rx_en_o
);
  localparam int AW = $clog2(WDOG_CYC + 2);

  logic [AW-1:0] awk_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       awk_cnt <= '0;
    else if (awake_o) awk_cnt <= awk_cnt + 1'b1;
    else              awk_cnt <= '0;
  end

  AST_SLEEP_AWAKE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(asleep_o && awake_o)); // R10
  AST_RX_NEEDS_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en_o |-> awake_o); // R10
  AST_WAKE_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep_o) |-> awake_o && !rx_en_o); // R2
  AST_RX_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_en_o) |-> awk_cnt == AW'(WAKE_DLY)); // R3
  AST_WDOG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    awake_o |-> awk_cnt < AW'(WDOG_CYC)); // R8
  AST_FORCE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep_o && !awake_o) |=> asleep_o); // R8
endmodule

bind line_power_ctrl lpc_checker #(
  .WAKE_DLY (WAKE_DLY),
  .WDOG_CYC (WDOG_CYC)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .asleep_o (asleep_o),
  .awake_o  (awake_o),
  .rx_en_o  (rx_en_o)
);

// File: tb/line_power_ctrl_tb_top.sv
module line_power_ctrl_tb_top;
  localparam int W  = 4;
  localparam int I  = 8;
  localparam int WD = 40;

  typedef struct {
    int unsigned at;
    logic [2:0]  exp;   // {asleep, awake, rx_en}
    string       req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_i = 1'b1;
  logic busy_i = 1'b0;
  logic asleep_o, awake_o, rx_en_o;

  int unsigned cyc = 0;
  int errors = 0;
  int checks = 0;
  exp_t sb_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  line_power_ctrl #(.WAKE_DLY(W), .IDLE_TMO(I), .WDOG_CYC(WD)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_i   (line_i),
    .busy_i   (busy_i),
    .asleep_o (asleep_o),
    .awake_o  (awake_o),
    .rx_en_o  (rx_en_o)
  );

  task automatic push_exp(input int unsigned at, input logic a, input logic w,
                          input logic r, input string req);
    exp_t e;
    e.at = at; e.exp = {a, w, r}; e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic wait_to(input int unsigned n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: compares the expected items that are due at each falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
      checks++;
      if (sb_q[0].at < cyc) begin
        errors++;
        $display("FAIL %s: check at cycle %0d missed (now %0d)", sb_q[0].req, sb_q[0].at, cyc);
      end else if ({asleep_o, awake_o, rx_en_o} !== sb_q[0].exp) begin
        errors++;
        $display("FAIL %s: cycle %0d {asleep,awake,rx_en} actual=%b expected=%b",
                 sb_q[0].req, cyc, {asleep_o, awake_o, rx_en_o}, sb_q[0].exp);
      end
      void'(sb_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int unsigned c, s, a;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    push_exp(cyc + 1, 1, 0, 0, "R1");
    wait_to(cyc + 3);

    // A: falling-edge wake, delay, idle timeout
    c = cyc; line_i = 1'b0;
    push_exp(c + 2, 1, 0, 0, "R2");
    push_exp(c + 3, 0, 1, 0, "R2");
    push_exp(c + 3 + W - 1, 0, 1, 0, "R3");
    push_exp(c + 3 + W, 0, 1, 1, "R3");
    push_exp(c + 3 + W + I - 1, 0, 1, 1, "R5");
    push_exp(c + 3 + W + I, 1, 0, 0, "R5");
    wait_to(c + 3 + W + I + 3);

    // B: rising-edge wake, edges in the delay ignored, edge restarts idle timer
    c = cyc; line_i = 1'b1;
    s = c + 3 + W; a = s + 3;
    push_exp(c + 3, 0, 1, 0, "R2");
    push_exp(c + 3 + W - 1, 0, 1, 0, "R4");
    push_exp(s, 0, 1, 1, "R4");
    push_exp(a + 2 + I, 0, 1, 1, "R6");
    push_exp(a + 3 + I, 1, 0, 0, "R6");
    wait_to(c + 3); line_i = 1'b0;
    wait_to(c + 4); line_i = 1'b1;
    wait_to(a);     line_i = 1'b0;
    wait_to(a + 3 + I + 3);

    // C: busy holds the idle timer
    c = cyc; line_i = 1'b1;
    s = c + 3 + W;
    push_exp(s + 8, 0, 1, 1, "R7");
    push_exp(s + 12, 0, 1, 1, "R7");
    push_exp(s + 13, 1, 0, 0, "R7");
    wait_to(s + 2); busy_i = 1'b1;
    wait_to(s + 7); busy_i = 1'b0;
    wait_to(s + 13 + 3);

    // D: watchdog fires despite busy and line activity
    c = cyc; line_i = 1'b0;
    push_exp(c + 2 + WD, 0, 1, 1, "R8");
    push_exp(c + 3 + WD, 0, 0, 0, "R8");
    push_exp(c + 4 + WD, 1, 0, 0, "R8");
    wait_to(c + 5); busy_i = 1'b1;
    for (int k = 10; k <= 30; k += 4) begin
      wait_to(c + k); line_i = ~line_i;
    end
    wait_to(c + 4 + WD); busy_i = 1'b0;
    wait_to(c + 4 + WD + 3);

    // E: new wake gets a full watchdog interval
    c = cyc; line_i = ~line_i; busy_i = 1'b1;
    push_exp(c + 2 + WD, 0, 1, 1, "R9");
    push_exp(c + 3 + WD, 0, 0, 0, "R10");
    push_exp(c + 4 + WD, 1, 0, 0, "R9");
    wait_to(c + 4 + WD); busy_i = 1'b0;
    wait_to(c + 4 + WD + 2);

    while (sb_q.size() > 0) @(negedge clk);
    finish_run();
  end
endmodule